// File: doc/BRIEF.md
# Posit Field Decoder

This block takes one posit word of a parameterised total width and exponent-field width and splits it into fixed-position fields. The outputs are a sign, one signed scale that combines the regime and exponent, and a normalised mantissa with the hidden one made explicit. The regime is a run of identical bits of variable length, so the exponent and fraction fields do not sit at fixed positions. The block therefore counts the leading run first. It then uses a logarithmic shifter to move the bits that follow the run up to the top of a fixed-width field.

Negative words are converted to their two's complement magnitude before the regime is read. The all-zero word and the not-a-real word (a one followed by zeros) are reported through flags. They are not decoded as numbers. The input word is sampled on each rising clock edge and the decoded fields are registered, so every result appears one cycle after its word. Downstream arithmetic, rounding and re-encoding belong to other blocks.

Top module: `posit_field_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every output is driven to zero at that edge: sign, scale, mantissa and both flags.
- R2: The outputs after a rising edge with `rst` low reflect only the `word_in` value sampled at that edge. The latency is exactly one cycle and back-to-back words do not interfere with each other.
- R3: When `word_in` is all zeros, `zero_o` is 1 and `nar_o`, `sign_o`, `scale_o` and `mant_o` are all 0.
- R4: When `word_in` has its top bit set and all other bits clear, `nar_o` is 1 and `zero_o`, `sign_o`, `scale_o` and `mant_o` are all 0.
- R5: For any other word, `sign_o` equals bit N-1 of the word. When that bit is 1, the regime, exponent and fraction are taken from the two's complement of the whole word.
- R6: When the bits below the sign start with m ones ended by a zero, the regime value is k = m-1.
- R7: When the bits below the sign start with m zeros ended by a one, the regime value is k = -m.
- R8: When the run fills all N-1 bits below the sign with no terminating bit, its length is N-1 (k = N-2 for ones), and the exponent and fraction read as zero.
- R9: Exponent bits that would lie past the least significant bit of the word read as zero. A partially cut exponent keeps its surviving bits in the upper positions of the exponent field.
- R10: `mant_o` has width N-2-ES. Bit N-3-ES is the hidden one. The N-3-ES bits below it are the fraction bits that follow the exponent, in word order, starting from the top, and positions past the end of the word are zero.
- R11: `scale_o` is the signed two's complement value k * 2^ES + e, where e is the unsigned exponent field. Its width is clog2(N * 2^ES) + 1 bits, and for a regular word its value lies in the range ±(N-2) * 2^ES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | N | Posit word sampled on each rising edge |
| sign_o | output | 1 | Sign of the decoded word |
| scale_o | output | clog2(N*2^ES)+1 | Signed combined scale k*2^ES+e |
| mant_o | output | N-2-ES | Hidden one followed by the fraction bits |
| zero_o | output | 1 | Word was all zeros |
| nar_o | output | 1 | Word was the not-a-real pattern |

## Verification
The hardest cases to reach are the regimes whose run ends at, or just before, the least significant bit. There the exponent is partly or wholly cut off, and negative words only land there after the two's complement step. Random words rarely produce such long runs. The stimulus therefore names the extreme words directly: the largest and smallest magnitudes, a run that leaves one exponent bit, and their negations. It then sweeps every one of the 2^16 words of the default format through a scoreboard. That sweep reaches every run length with both polarities and both signs.

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

    typedef enum logic [1:0] {
        CLS_REAL = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_NAR  = 2'd2
    } word_class_e;

    // Fraction bits left after sign, shortest regime (two bits) and exponent.
    function automatic int frac_bits(input int n, input int es);
        return n - 3 - es;
    endfunction

    // Signed width holding +/-(n-2)*2^es.
    function automatic int scale_bits(input int n, input int es);
        return $clog2(n << es) + 1;
    endfunction

    // Width of a run length counted over n-1 bits.
    function automatic int run_bits(input int n);
        return $clog2(n);
    endfunction

    // Width of a shift amount that may reach n.
    function automatic int shift_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pd_run_counter.sv
module pd_run_counter #(
    parameter int W  = 15,
    parameter int CW = 4
) (
    input  logic [W-1:0]  bits_in,
    output logic          lead_o,
    output logic [CW-1:0] len_o
);

    logic [W-1:0] flipped;
    logic         found;

    assign lead_o  = bits_in[W-1];
    // After inversion the run becomes leading zeros.
    assign flipped = bits_in[W-1] ? ~bits_in : bits_in;

    always_comb begin
        len_o = CW'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && flipped[i]) begin
                len_o = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pd_field_shifter.sv
module pd_field_shifter #(
    parameter int W  = 15,
    parameter int SW = 5
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stg [SW+1];

    assign stg[0] = din;

    for (genvar g = 0; g < SW; g++) begin : g_stage
        // Each stage shifts by a power of two; zeros enter from the bottom.
        assign stg[g+1] = amt[g] ? (stg[g] << (2 ** g)) : stg[g];
    end

    assign dout = stg[SW];

endmodule

// File: rtl/pd_scale_builder.sv
module pd_scale_builder #(
    parameter int CW  = 4,
    parameter int ES  = 2,
    parameter int SCW = 7
) (
    input  logic                  lead,
    input  logic [CW-1:0]         run_len,
    input  logic [ES-1:0]         exp_bits,
    output logic signed [SCW-1:0] scale
);

    logic signed [SCW-1:0] len_s;
    logic signed [SCW-1:0] one_s;
    logic signed [SCW-1:0] k_s;
    logic [ES-1:0]         unused_k_top;

    assign len_s = $signed({{(SCW-CW){1'b0}}, run_len});
    assign one_s = $signed({{(SCW-1){1'b0}}, 1'b1});
    assign k_s   = lead ? (len_s - one_s) : -len_s;

    // k * 2^ES + e: the low ES bits of the shifted k are zero, so append e.
    assign scale        = $signed({k_s[SCW-ES-1:0], exp_bits});
    assign unused_k_top = k_s[SCW-1 -: ES];

endmodule

// File: rtl/posit_field_decoder.sv
module posit_field_decoder
    import posit_dec_pkg::*;
#(
    parameter int N  = 16,
    parameter int ES = 2
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [N-1:0]                          word_in,
    output logic                                  sign_o,
    output logic signed [scale_bits(N, ES)-1:0]   scale_o,
    output logic [frac_bits(N, ES):0]             mant_o,
    output logic                                  zero_o,
    output logic                                  nar_o
);

    localparam int BW  = N - 1;
    localparam int FW  = frac_bits(N, ES);
    localparam int SCW = scale_bits(N, ES);
    localparam int CW  = run_bits(N);
    localparam int AW  = shift_bits(N);
    localparam int TW  = BW - ES - FW;

    typedef struct packed {
        logic                  sgn;
        logic signed [SCW-1:0] scale;
        logic [FW:0]           mant;
        logic                  zero;
        logic                  nar;
    } dec_t;

    word_class_e           cls;
    logic [BW-1:0]         body;
    logic                  lead;
    logic [CW-1:0]         run_len;
    logic [AW-1:0]         amt;
    logic [BW-1:0]         shifted;
    logic [ES-1:0]         exp_bits;
    logic [FW-1:0]         frac;
    logic [TW-1:0]         unused_tail;
    logic signed [SCW-1:0] scale_c;
    dec_t                  nxt;
    dec_t                  q;

    always_comb begin
        if (word_in == '0)
            cls = CLS_ZERO;
        else if (word_in[N-1] && (word_in[N-2:0] == '0))
            cls = CLS_NAR;
        else
            cls = CLS_REAL;
    end

    // Low N-1 bits of the negated word equal the negation of the low bits.
    assign body = word_in[N-1] ? (~word_in[N-2:0] + 1'b1) : word_in[N-2:0];

    pd_run_counter #(
        .W  (BW),
        .CW (CW)
    ) u_run (
        .bits_in (body),
        .lead_o  (lead),
        .len_o   (run_len)
    );

    // Drop the run and its terminating bit.
    assign amt = AW'(run_len) + AW'(1);

    pd_field_shifter #(
        .W  (BW),
        .SW (AW)
    ) u_shift (
        .din  (body),
        .amt  (amt),
        .dout (shifted)
    );

    assign exp_bits    = shifted[BW-1 -: ES];
    assign frac        = shifted[BW-1-ES -: FW];
    assign unused_tail = shifted[TW-1:0];

    pd_scale_builder #(
        .CW  (CW),
        .ES  (ES),
        .SCW (SCW)
    ) u_scale (
        .lead     (lead),
        .run_len  (run_len),
        .exp_bits (exp_bits),
        .scale    (scale_c)
    );

    always_comb begin
        nxt = '0;
        unique case (cls)
            CLS_ZERO: nxt.zero = 1'b1;
            CLS_NAR:  nxt.nar  = 1'b1;
            default: begin
                nxt.sgn   = word_in[N-1];
                nxt.scale = scale_c;
                nxt.mant  = {1'b1, frac};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    assign sign_o  = q.sgn;
    assign scale_o = q.scale;
    assign mant_o  = q.mant;
    assign zero_o  = q.zero;
    assign nar_o   = q.nar;

endmodule

// File: rtl/posit_field_decoder_chk.sv
module posit_field_decoder_chk #(
    parameter int N   = 16,
    parameter int ES  = 2,
    parameter int SCW = 7,
    parameter int FW  = 11
) (
    input logic                  clk,
    input logic                  rst,
    input logic [N-1:0]          word_in,
    input logic                  sign_o,
    input logic signed [SCW-1:0] scale_o,
    input logic [FW:0]           mant_o,
    input logic                  zero_o,
    input logic                  nar_o
);

    localparam logic [N-1:0] NAR_W    = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MAXPOS_W = {1'b0, {(N-1){1'b1}}};
    localparam logic [N-1:0] MINPOS_W = {{(N-1){1'b0}}, 1'b1};
    localparam int           LIMIT    = (N - 2) << ES;

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (word_in == '0) |=> (zero_o && !nar_o && !sign_o && mant_o == '0 && scale_o == '0)); // R3

    AST_NAR_FLAG: assert property (@(posedge clk) disable iff (rst)
        (word_in == NAR_W) |=> (nar_o && !zero_o && !sign_o && mant_o == '0 && scale_o == '0)); // R4

    AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (rst)
        (word_in != '0 && word_in != NAR_W) |=> (sign_o == $past(word_in[N-1]) && mant_o[FW] && !zero_o && !nar_o)); // R5

    AST_ONES_TOP: assert property (@(posedge clk) disable iff (rst)
        (word_in == MAXPOS_W) |=> (scale_o == LIMIT && mant_o == {1'b1, {FW{1'b0}}})); // R8

    AST_ZEROS_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        (word_in == MINPOS_W) |=> (scale_o == -LIMIT && !sign_o)); // R7

    AST_SCALE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (!zero_o && !nar_o) |-> (scale_o >= -LIMIT && scale_o <= LIMIT)); // R11

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(zero_o && nar_o)); // R3

endmodule

bind posit_field_decoder posit_field_decoder_chk #(
    .N   (N),
    .ES  (ES),
    .SCW (SCW),
    .FW  (FW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .word_in (word_in),
    .sign_o  (sign_o),
    .scale_o (scale_o),
    .mant_o  (mant_o),
    .zero_o  (zero_o),
    .nar_o   (nar_o)
);

// File: tb/posit_field_decoder_tb.sv
`timescale 1ns/1ps
module posit_field_decoder_tb;

    localparam int N   = 16;
    localparam int ES  = 2;
    localparam int FW  = N - 3 - ES;
    localparam int SCW = $clog2(N << ES) + 1;

    typedef struct packed {
        logic                  sgn;
        logic signed [SCW-1:0] scale;
        logic [FW:0]           mant;
        logic                  z;
        logic                  n;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst;
    logic [N-1:0]          word;
    logic                  sign_o;
    logic signed [SCW-1:0] scale_o;
    logic [FW:0]           mant_o;
    logic                  zero_o;
    logic                  nar_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t  q_exp[$];
    string q_tag[$];

    always #2 clk = ~clk;

    posit_field_decoder #(.N(N), .ES(ES)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .word_in (word),
        .sign_o  (sign_o),
        .scale_o (scale_o),
        .mant_o  (mant_o),
        .zero_o  (zero_o),
        .nar_o   (nar_o)
    );

    // Reference built directly from the requirement text.
    function automatic exp_t model(input logic [N-1:0] w, output string cls_tag);
        exp_t         r;
        logic [N-1:0] a;
        logic         rb;
        int           m, i, k, pos, e;
        r = '0;
        cls_tag = "";
        if (w == '0) begin
            r.z = 1'b1; cls_tag = "R3"; return r;
        end
        if (w == {1'b1, {(N-1){1'b0}}}) begin
            r.n = 1'b1; cls_tag = "R4"; return r;
        end
        r.sgn = w[N-1];
        a  = w[N-1] ? (~w + 1'b1) : w;
        rb = a[N-2];
        m  = 0;
        i  = N - 2;
        while (i >= 0 && a[i] == rb) begin
            m++;
            i--;
        end
        k   = rb ? m - 1 : -m;
        pos = N - 3 - m;
        e   = 0;
        for (int j = 0; j < ES; j++)
            e = e * 2 + (((pos - j) >= 0) ? int'(a[pos-j]) : 0);
        r.mant[FW] = 1'b1;
        for (int j = 0; j < FW; j++)
            if ((pos - ES - j) >= 0) r.mant[FW-1-j] = a[pos-ES-j];
        r.scale = SCW'(k * (1 << ES) + e);
        if (m == N - 1)  cls_tag = "R8";
        else if (rb)     cls_tag = "R6";
        else             cls_tag = "R7";
        return r;
    endfunction

    task automatic drive(input logic [N-1:0] w, input string tag);
        string cls_tag;
        exp_t  x;
        @(negedge clk);
        word = w;
        x = model(w, cls_tag);
        q_exp.push_back(x);
        q_tag.push_back((tag == "") ? cls_tag : tag);
    endtask

    // Monitor: compares one item per edge once the queue holds one.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && q_exp.size() > 0) begin
                exp_t  x;
                string t;
                exp_t  got;
                x   = q_exp.pop_front();
                t   = q_tag.pop_front();
                got = '{sgn: sign_o, scale: scale_o, mant: mant_o, z: zero_o, n: nar_o};
                checks++;
                if (got !== x) begin
                    fails++;
                    $display("FAIL %s: got sign=%0b scale=%0d mant=%h zero=%0b nar=%0b, expected sign=%0b scale=%0d mant=%h zero=%0b nar=%0b",
                             t, got.sgn, got.scale, got.mant, got.z, got.n,
                             x.sgn, x.scale, x.mant, x.z, x.n);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion, expected end within 200000 cycles");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst  = 1'b1;
        word = 16'h4000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared while reset is held, despite a live word.
        checks++;
        if ({sign_o, scale_o, mant_o, zero_o, nar_o} !== '0) begin
            fails++;
            $display("FAIL R1: got sign=%0b scale=%0d mant=%h zero=%0b nar=%0b, expected all zero",
                     sign_o, scale_o, mant_o, zero_o, nar_o);
        end
        rst = 1'b0;

        drive(16'h0000, "R3 zero word");
        drive(16'h8000, "R4 not-a-real word");
        drive(16'h4000, "R6 one-run k=0");
        drive(16'h6000, "R6 two-run k=1");
        drive(16'h2000, "R7 zero-run k=-1");
        drive(16'h7FFF, "R8 full ones run");
        drive(16'h0001, "R7 R9 minimum magnitude");
        drive(16'h7FFD, "R9 one surviving exponent bit");
        drive(16'h4800, "R11 exponent one");
        drive(16'h5A5A, "R10 fraction placement");
        drive(16'hFFFF, "R5 negative minimum magnitude");
        drive(16'hC000, "R5 negative one");
        drive(16'h8001, "R5 negative full ones run");
        drive(16'h4000, "R2 back-to-back a");
        drive(16'hC000, "R2 back-to-back b");
        drive(16'h0000, "R2 back-to-back c");
        drive(16'h8000, "R2 back-to-back d");

        // Exhaustive sweep, tagged by word class.
        for (int v = 0; v < (1 << N); v++)
            drive(N'(v), "");

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (q_exp.size() != 0) begin
            fails++;
            $display("FAIL R2: got %0d pending results, expected 0", q_exp.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule